// File: doc/BRIEF.md
# Pipelined Burst Static RAM with Dual Address Strobes

This block is a synchronous static RAM of four byte lanes, nine bits per lane, with its storage array on chip. Every control input is active low and sampled on the rising clock edge. A master opens an access with one of two address strobes: a processor strobe and a controller strobe. It then steps through a four-word block with the advance input. A two-bit burst counter supplies the low address bits of each beat. Writes come in two forms: a global write that fills every lane, or a per-lane write that needs a byte-write enable plus one select per lane.

Read data passes through a two-register pipeline. The word for an address that is sampled on one rising edge is driven after the following rising edge. There are no tri-state pins. The data paths for input and output are separate, and an output-valid flag combines the asynchronous output-enable input with the pipeline state. That flag stays low during the first cycle of a read that starts from the deselected state.

Top module: `burst_sram`

## Requirements
- R1: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on the sampling edge. A strobe that is taken while the device is not selected deselects it. A deselected device performs no write and returns no read data until a strobe is taken while it is selected.
- R2: A strobe that is taken while the device is selected captures the whole of `addr`. It also loads `addr[1:0]` into the burst counter, and that edge accesses the captured address.
- R3: When both strobes are low in one cycle, only the processor strobe acts. A processor-strobe cycle is always a read, and its write controls are ignored. A controller-strobe cycle with a write request writes.
- R4: The processor strobe is ignored whenever `ce1_n` is high. With the controller strobe high in that cycle, the burst state goes on as if no strobe were present.
- R5: When neither strobe is taken and `adv_n` is low during an access, the counter steps +1 modulo 4. The upper address bits stay fixed, so the beats of a block run in linear order with wrap (for example 2,3,0,1).
- R6: When neither strobe is taken and `adv_n` is high, the access repeats the same address.
- R7: With `gw_n` low, all four lanes of the addressed word are written from `din`, whatever the values of `bwe_n` and `bsel_n`.
- R8: With `gw_n` high, lane k (`din[9k+8:9k]`) is written only if `bwe_n` is low and `bsel_n[k]` is low. A cycle with `bwe_n` low is a write cycle and returns no read data. With both `gw_n` and `bwe_n` high, the cycle is a read.
- R9: Read data for the address accessed at edge N appears on `dout` after edge N+1, with `dq_oe` high when `oe_n` is low.
- R10: `dq_oe` is low whenever `oe_n` is high, and is never high in a cycle that carries no read data.
- R11: In the cycle after a strobe edge that leaves the deselected state, `dq_oe` stays low even with `oe_n` low.
- R12: After reset the device is deselected and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | Read data on `dout` is valid and enabled |

## Verification
A counter that advances wrongly or fails to wrap returns the wrong stored word on the second beat of a burst, two edges after that beat was sampled. That shows only if adjacent words of the array hold distinct data, so the array is first filled with random contents. A wrong strobe decision, such as letting the processor strobe act under a high `ce1_n` or letting it write, comes to light on a later read of the affected word, or as a `dq_oe` that stays low where data was due. An error in the valid pipeline shows within one cycle as a `dq_oe` mismatch, mainly on the first read after a deselect.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int unsigned BURST_W = 2;

  typedef logic [BURST_W-1:0] burst_t;

  // all three enables must agree for the device to be selected
  function automatic logic chip_selected(input logic ce1_n, input logic ce2,
                                         input logic ce3_n);
    return !ce1_n && ce2 && !ce3_n;
  endfunction

  // the processor strobe counts only while chip enable 1 is low
  function automatic logic proc_strobe_taken(input logic adsp_n, input logic ce1_n);
    return !adsp_n && !ce1_n;
  endfunction

  // linear burst order, wrapping inside the four-word block
  function automatic burst_t burst_step(input burst_t cur);
    return cur + burst_t'(1);
  endfunction

endpackage

// File: rtl/bsr_addr_ctrl.sv
module bsr_addr_ctrl
  import burst_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  output logic              acc_active,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              proc_cycle,
  output logic              load_now,
  output logic              active_q
);

  localparam int unsigned HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0] hi_q, hi_nxt;
  burst_t          cnt_q, cnt_nxt;
  logic            sel_now, strobe_now, drop_now, step_now, act_nxt;

  always_comb begin
    sel_now    = chip_selected(ce1_n, ce2, ce3_n);
    proc_cycle = proc_strobe_taken(adsp_n, ce1_n);
    strobe_now = proc_cycle || !adsc_n;
    load_now   = strobe_now && sel_now;
    drop_now   = strobe_now && !sel_now;
    step_now   = !strobe_now && active_q && !adv_n;

    if (load_now)      cnt_nxt = addr[BURST_W-1:0];
    else if (step_now) cnt_nxt = burst_step(cnt_q);
    else               cnt_nxt = cnt_q;

    hi_nxt  = load_now ? addr[ADDR_W-1:BURST_W] : hi_q;

    if (load_now)      act_nxt = 1'b1;
    else if (drop_now) act_nxt = 1'b0;
    else               act_nxt = active_q;
  end

  assign acc_active = act_nxt;
  assign acc_addr   = {hi_nxt, cnt_nxt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      hi_q     <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= act_nxt;
      hi_q     <= hi_nxt;
      cnt_q    <= cnt_nxt;
    end
  end

  // R1: a strobe seen while the enables do not select deselects the device
  p_strobe_unselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (((!adsp_n && !ce1_n) || !adsc_n) && !(!ce1_n && ce2 && !ce3_n)) |=> !active_q)
    else $error("p_strobe_unselected_r1");

  // R2: a taken strobe while selected captures the full address
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (active_q && {hi_q, cnt_q} == $past(addr)))
    else $error("p_capture_r2");

  // R4: with chip enable 1 high and no controller strobe, state carries on
  p_ce1_masks_proc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && adsc_n) |=> (active_q == $past(active_q) && hi_q == $past(hi_q)))
    else $error("p_ce1_masks_proc_r4");

  // R5: advance steps the counter with wrap, upper bits unchanged
  p_burst_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && adsp_n && adsc_n && !adv_n)
      |=> (cnt_q == burst_t'($past(cnt_q) + burst_t'(1)) && $stable(hi_q)))
    else $error("p_burst_wrap_r5");

  // R6: no strobe and no advance keeps the address
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adsp_n && adsc_n && adv_n) |=> ($stable(cnt_q) && $stable(hi_q) && $stable(active_q)))
    else $error("p_hold_r6");

endmodule

// File: rtl/bsr_lane_decode.sv
module bsr_lane_decode #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycle_ok,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  output logic [LANES-1:0] lane_we,
  output logic             wr_cycle
);

  assign wr_cycle = cycle_ok && (!gw_n || !bwe_n);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // global write overrides the byte-enable path
    assign lane_we[g] = cycle_ok && (!gw_n || (!bwe_n && !bsel_n[g]));
  end

  // R7: global write reaches every lane
  p_global_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_ok && !gw_n) |-> (lane_we == {LANES{1'b1}}))
    else $error("p_global_all_r7");

  // R8: no write enable of either kind means no lane strobe
  p_byte_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && bwe_n) |-> (lane_we == '0))
    else $error("p_byte_gate_r8");

  // R8: any lane strobe implies the cycle is a write cycle
  p_lane_in_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> wr_cycle)
    else $error("p_lane_in_write_r8");

endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)      rd_q        <= cells[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dq_oe
);

  localparam int unsigned DATA_W = LANES * LANE_W;

  logic              acc_active, proc_cycle, load_now, active_q;
  logic [ADDR_W-1:0] acc_addr;
  logic              cycle_ok, wr_cycle, rd_issue;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rd_stage1, dout_q;
  logic              rd_v1_q, rd_v2_q, from_idle_q;

  bsr_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .adsp_n     (adsp_n),
    .adsc_n     (adsc_n),
    .adv_n      (adv_n),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .acc_active (acc_active),
    .acc_addr   (acc_addr),
    .proc_cycle (proc_cycle),
    .load_now   (load_now),
    .active_q   (active_q)
  );

  // a processor-strobe cycle is read-only
  assign cycle_ok = acc_active && !proc_cycle;

  bsr_lane_decode #(.LANES(LANES)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cycle_ok (cycle_ok),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bsel_n   (bsel_n),
    .lane_we  (lane_we),
    .wr_cycle (wr_cycle)
  );

  assign rd_issue = acc_active && !wr_cycle;

  bsr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .lane_we (lane_we),
    .rd_en   (rd_issue),
    .addr    (acc_addr),
    .wdata   (din),
    .rdata   (rd_stage1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v1_q     <= 1'b0;
      rd_v2_q     <= 1'b0;
      from_idle_q <= 1'b0;
    end else begin
      rd_v1_q     <= rd_issue;
      rd_v2_q     <= rd_v1_q;
      from_idle_q <= load_now && !active_q;
    end
  end

  always_ff @(posedge clk) dout_q <= rd_stage1;

  assign dout  = dout_q;
  assign dq_oe = !oe_n && rd_v2_q;

  // R3: a processor-strobe cycle never strobes a lane
  p_proc_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    proc_cycle |-> (lane_we == '0))
    else $error("p_proc_no_write_r3");

  // R3: a cycle that writes does not also issue a read
  p_write_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> !rd_issue)
    else $error("p_write_no_read_r3");

  // R9: a read issued now is presented two edges later
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> ##1 (dq_oe || oe_n))
    else $error("p_latency_r9");

  // R10: output enable high always blanks the data valid flag
  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe)
    else $error("p_oe_gate_r10");

  // R11: first cycle after leaving deselect carries no data
  p_first_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    from_idle_q |-> !dq_oe)
    else $error("p_first_mask_r11");

endmodule

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;

  localparam int AW    = 6;
  localparam int NL    = 4;
  localparam int LW    = 9;
  localparam int DW    = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n;
  logic [NL-1:0] bsel_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic dq_oe;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R9";
  bit done = 1'b0;

  // reference model state
  logic [DW-1:0] ref_mem [DEPTH];
  bit            m_act;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  bit            m_v1, m_v2;
  logic [DW-1:0] m_d1, m_d2;

  always #5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .din(din), .dout(dout),
    .dq_oe(dq_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rand_word();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  // model of one clock edge, written from the requirements
  function automatic void model_edge();
    bit sel, ptake, strobe, wr;
    logic [AW-1:0] eff;
    sel    = (ce1_n == 1'b0) && (ce2 == 1'b1) && (ce3_n == 1'b0);
    ptake  = (adsp_n == 1'b0) && (ce1_n == 1'b0);
    strobe = ptake || (adsc_n == 1'b0);
    if (strobe) begin
      if (sel) begin
        m_act = 1'b1;
        m_base = addr;
        m_cnt = addr[1:0];
      end else begin
        m_act = 1'b0;
      end
    end else if (m_act && adv_n == 1'b0) begin
      m_cnt = (m_cnt == 2'd3) ? 2'd0 : m_cnt + 2'd1;
    end
    eff = {m_base[AW-1:2], m_cnt};
    wr  = m_act && !ptake && (gw_n == 1'b0 || bwe_n == 1'b0);
    m_v2 = m_v1;
    m_d2 = m_d1;
    m_v1 = m_act && !wr;
    m_d1 = ref_mem[eff];
    if (wr) begin
      for (int k = 0; k < NL; k++)
        if (gw_n == 1'b0 || bsel_n[k] == 1'b0)
          ref_mem[eff][k*LW +: LW] = din[k*LW +: LW];
    end
  endfunction

  task automatic step();
    bit exp_oe;
    @(posedge clk);
    model_edge();
    #1;
    exp_oe = m_v2 && (oe_n == 1'b0);
    check(dq_oe == exp_oe, {cur_tag, " dq_oe"}, {35'd0, dq_oe}, {35'd0, exp_oe});
    if (exp_oe && dq_oe)
      check(dout == m_d2, {cur_tag, " dout"}, dout, m_d2);
    @(negedge clk);
  endtask

  task automatic quiet();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1;
    oe_n = 1'b0; din = '0; addr = '0;
  endtask

  task automatic deselect();
    quiet();
    adsc_n = 1'b0; ce2 = 1'b0;
    step();
    quiet();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0de5));
    quiet();
    m_act = 0; m_base = '0; m_cnt = '0; m_v1 = 0; m_v2 = 0; m_d1 = '0; m_d2 = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12: reset leaves outputs disabled
    check(dq_oe == 1'b0, "R12 reset dq_oe", {35'd0, dq_oe}, '0);
    @(negedge clk);

    // R7: fill every word with a controller-strobe global write
    cur_tag = "R7";
    for (int a = 0; a < DEPTH; a++) begin
      quiet();
      adsc_n = 1'b0; addr = AW'(a); gw_n = 1'b0; bwe_n = $urandom() % 2 == 0;
      bsel_n = NL'($urandom()); din = rand_word();
      step();
    end
    quiet(); step(); step();

    // R11 + R2: read from deselected, first cycle has no data
    deselect();
    cur_tag = "R11";
    adsc_n = 1'b0; addr = 6'd13;
    step();
    quiet();
    cur_tag = "R2";
    step(); step();

    // R5: four-beat read burst from offset 2 wraps 2,3,0,1
    cur_tag = "R5";
    adsp_n = 1'b0; addr = 6'd22;
    step();
    quiet();
    for (int b = 0; b < 3; b++) begin adv_n = 1'b0; step(); end
    quiet(); step(); step();

    // R6: no advance repeats the address
    cur_tag = "R6";
    adsc_n = 1'b0; addr = 6'd41;
    step();
    quiet(); step(); step(); step();

    // R3: both strobes with global write: read only, no write
    cur_tag = "R3";
    adsp_n = 1'b0; adsc_n = 1'b0; addr = 6'd7; gw_n = 1'b0; din = rand_word();
    step();
    quiet(); step();
    adsc_n = 1'b0; addr = 6'd7; step();
    quiet(); step(); step();
    // R3: controller strobe alone with write does write
    adsc_n = 1'b0; addr = 6'd8; gw_n = 1'b0; din = rand_word();
    step();
    quiet(); adsc_n = 1'b0; addr = 6'd8; step();
    quiet(); step(); step();

    // R4: processor strobe with ce1_n high during a burst is ignored
    cur_tag = "R4";
    adsc_n = 1'b0; addr = 6'd32;
    step();
    quiet(); adv_n = 1'b0; step();
    adsp_n = 1'b0; ce1_n = 1'b1; adv_n = 1'b0; addr = 6'd60; step();
    quiet(); adv_n = 1'b0; step();
    quiet(); step(); step();

    // R1: strobe with a chip enable wrong deselects; writes then ignored
    cur_tag = "R1";
    adsc_n = 1'b0; ce3_n = 1'b1; addr = 6'd50; gw_n = 1'b0; din = rand_word();
    step();
    quiet(); gw_n = 1'b0; din = rand_word(); addr = 6'd50; step();
    quiet(); step();
    adsc_n = 1'b0; addr = 6'd50; step();
    quiet(); step(); step();

    // R8: byte writes with assorted lane masks
    cur_tag = "R8";
    for (int i = 0; i < 16; i++) begin
      quiet();
      adsc_n = 1'b0; addr = AW'(i * 3); bwe_n = 1'b0; bsel_n = NL'(i); din = rand_word();
      step();
      quiet(); adsc_n = 1'b0; addr = AW'(i * 3); step();
      quiet(); step();
    end
    step();

    // R10: output enable high blanks a read
    cur_tag = "R10";
    adsc_n = 1'b0; addr = 6'd9; step();
    quiet(); oe_n = 1'b1; step(); step();
    quiet(); step();

    // R9: random mixed traffic
    cur_tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom());
      quiet();
      adsp_n = (r % 7) != 0;
      adsc_n = ((r >> 3) % 5) != 0;
      adv_n  = ((r >> 6) % 3) == 0;
      ce1_n  = ((r >> 8) % 9) == 0;
      ce2    = ((r >> 12) % 11) != 0;
      ce3_n  = ((r >> 16) % 13) == 0;
      gw_n   = ((r >> 20) % 6) != 0;
      bwe_n  = ((r >> 23) % 4) != 0;
      bsel_n = NL'(r >> 26);
      oe_n   = ((r >> 30) % 2) == 1 && (i % 5 == 0);
      addr   = AW'($urandom());
      din    = rand_word();
      step();
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule